// File: doc/BRIEF.md
# Linked-List Command Chain Walker

The walker follows a chain of command blocks kept in system memory and forwards their contents to a command consumer. Each block begins with one header word. The top byte of the header gives how many payload words follow it. The low 24 bits give the address of the next block. After a start pulse the walker reads a header and then the payload words that sit directly behind it. It hands each payload word to the consumer over a valid/ready stream, then moves to the linked block. A link whose top bit is set closes the chain.

While walking, the walker adds up an estimated cost for the list, charged per block. It also counts the blocks it visits. A malformed list that loops forever is cut off once the block count reaches a fixed limit, and this is reported with an error flag. Memory is read through a simple request/acknowledge port with one read in flight at a time, and the data comes back on a separate valid strobe.

Top module: `chain_walker`

## Requirements
- R1: A header word carries the payload length in words in bits 31:24 and the 24-bit link to the next block in bits 23:0.
- R2: The walk finishes when the link to be followed has bit 23 set. A start address with bit 23 set finishes with zero cost, no payload and no memory read.
- R3: A block address uses only link bits 20:0, with bits 1:0 forced to zero. Payload word i (counting from 0) is read at block address + 4·(i+1), and the sum wraps within 21 bits.
- R4: A block with length 0 sends no payload, and the walk goes straight on to its link.
- R5: The cost grows by 10 for every block, plus 5 + length for a block whose length is non-zero. The total is on cost_o in the done cycle and stays there until the next start.
- R6: After LOOP_LIMIT (default 8192) blocks, if the next link still lacks bit 23, the walk stops with loop_err_o = 1. Otherwise loop_err_o is 0 on completion.
- R7: Each payload word appears on cmd_data_o exactly once and in list order. While cmd_valid_o is high and cmd_ready_i is low, valid and data hold steady.
- R8: done_o is a single-cycle pulse at the end of every walk, and busy_o is high from the cycle after an accepted start through the done cycle.
- R9: A start pulse while busy_o is high is ignored and does not change the walk in progress or its results.
- R10: After reset, busy_o, done_o, cmd_valid_o, mem_req_o and loop_err_o are 0.
- R11: mem_req_o holds with a stable address until mem_ack_i, and no read is requested while a payload word waits on the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a walk (accepted when idle) |
| start_addr_i | input | 24 | Link of the first block |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 21 | Byte address of the read, word aligned |
| mem_ack_i | input | 1 | Request accepted this cycle |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| cmd_valid_o | output | 1 | Payload word valid |
| cmd_data_o | output | 32 | Payload word |
| cmd_ready_i | input | 1 | Consumer takes the word |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | Walk finished (one cycle) |
| cost_o | output | 32 | Accumulated cost |
| loop_err_o | output | 1 | Walk was cut off by the block limit |

## Verification
A start driven before a rising edge is registered at that edge, so busy_o is due one cycle later. done_o comes two cycles after the last header or payload handshake, one cycle for the end-of-link check and one for the done state. The bench drives every input on the falling edge and samples on the falling edge. It waits for the done pulse itself and does not count cycles, because memory acknowledges and consumer ready are throttled by a pseudo-random pattern. Payload words are counted and summed at the rising edge where valid and ready are both high. The totals are complete before done_o rises, and cost_o and loop_err_o are read in the done cycle.

// File: rtl/chain_walker_pkg.sv
package chain_walker_pkg;

    typedef enum logic [2:0] {
        CW_IDLE,
        CW_CHECK,
        CW_HREQ,
        CW_HWAIT,
        CW_PREQ,
        CW_PWAIT,
        CW_POUT,
        CW_DONE
    } cw_state_e;

endpackage

// File: rtl/chain_walker_tally.sv
module chain_walker_tally #(
    parameter int LEN_W      = 8,
    parameter int COST_W     = 32,
    parameter int NODE_COST  = 10,
    parameter int PAY_COST   = 5,
    parameter int LOOP_LIMIT = 8192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              add_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic [COST_W-1:0] cost_o,
    output logic              limit_hit_o
);

    localparam int CNT_W = $clog2(LOOP_LIMIT + 1);

    typedef struct packed {
        logic [COST_W-1:0] cost;
        logic [CNT_W-1:0]  cnt;
    } tally_t;

    tally_t tly_d, tly_q;
    logic [COST_W-1:0] inc;

    always_comb begin
        tly_d = tly_q;
        inc   = COST_W'(NODE_COST);
        if (len_i != '0) begin
            inc = inc + COST_W'(PAY_COST) + COST_W'(len_i);
        end
        if (clear_i) begin
            tly_d.cost = '0;
            tly_d.cnt  = '0;
        end else if (add_i) begin
            tly_d.cost = tly_q.cost + inc;
            tly_d.cnt  = tly_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tly_q <= '0;
        end else begin
            tly_q <= tly_d;
        end
    end

    assign cost_o      = tly_q.cost;
    assign limit_hit_o = (tly_q.cnt == CNT_W'(LOOP_LIMIT));

    // R6: the block counter never passes the limit
    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tly_q.cnt <= CNT_W'(LOOP_LIMIT));

    // R5: between starts the cost only grows
    assert_cost_grows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> tly_q.cost >= $past(tly_q.cost));

endmodule

// File: rtl/chain_walker_hold.sv
module chain_walker_hold #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              ready_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o
);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } hold_t;

    hold_t hld_d, hld_q;

    always_comb begin
        hld_d = hld_q;
        if (hld_q.valid && ready_i) begin
            hld_d.valid = 1'b0;
        end
        if (load_i) begin
            hld_d.valid = 1'b1;
            hld_d.data  = data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hld_q <= '0;
        end else begin
            hld_q <= hld_d;
        end
    end

    assign valid_o = hld_q.valid;
    assign data_o  = hld_q.data;

    // R7: a stalled word stays put
    assert_cmd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !ready_i |=> valid_o && $stable(data_o));

endmodule

// File: rtl/chain_walker_seq.sv
module chain_walker_seq
    import chain_walker_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int MEM_AW  = 21,
    parameter int DATA_W  = 32,
    parameter int LEN_W   = 8,
    parameter int END_BIT = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    output logic              mem_req_o,
    output logic [MEM_AW-1:0] mem_addr_o,
    input  logic              mem_ack_i,
    input  logic              mem_rvalid_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              limit_hit_i,
    input  logic              fire_i,
    output logic              clear_o,
    output logic              hdr_take_o,
    output logic [LEN_W-1:0]  hdr_len_o,
    output logic              load_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o
);

    typedef struct packed {
        cw_state_e         state;
        logic [ADDR_W-1:0] link;
        logic [MEM_AW-1:0] base;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  idx;
        logic              err;
    } seq_t;

    seq_t sq_d, sq_q;
    logic [MEM_AW-1:0] pay_addr;
    logic [LEN_W-1:0]  rd_len;
    logic              last_word;

    assign rd_len    = mem_rdata_i[DATA_W-1 -: LEN_W];
    assign pay_addr  = sq_q.base + ((MEM_AW'(sq_q.idx) + MEM_AW'(1)) << 2);
    assign last_word = ({1'b0, sq_q.idx} + (LEN_W+1)'(1)) == {1'b0, sq_q.len};

    always_comb begin
        sq_d       = sq_q;
        clear_o    = 1'b0;
        hdr_take_o = 1'b0;
        load_o     = 1'b0;
        unique case (sq_q.state)
            CW_IDLE: begin
                if (start_i) begin
                    sq_d.link  = start_addr_i;
                    sq_d.err   = 1'b0;
                    clear_o    = 1'b1;
                    sq_d.state = CW_CHECK;
                end
            end
            CW_CHECK: begin
                if (sq_q.link[END_BIT]) begin
                    sq_d.state = CW_DONE;
                end else if (limit_hit_i) begin
                    sq_d.err   = 1'b1;
                    sq_d.state = CW_DONE;
                end else begin
                    sq_d.base  = {sq_q.link[MEM_AW-1:2], 2'b00};
                    sq_d.state = CW_HREQ;
                end
            end
            CW_HREQ: begin
                if (mem_ack_i) sq_d.state = CW_HWAIT;
            end
            CW_HWAIT: begin
                if (mem_rvalid_i) begin
                    hdr_take_o = 1'b1;
                    sq_d.len   = rd_len;
                    sq_d.link  = mem_rdata_i[ADDR_W-1:0];
                    sq_d.idx   = '0;
                    sq_d.state = (rd_len == '0) ? CW_CHECK : CW_PREQ;
                end
            end
            CW_PREQ: begin
                if (mem_ack_i) sq_d.state = CW_PWAIT;
            end
            CW_PWAIT: begin
                if (mem_rvalid_i) begin
                    load_o     = 1'b1;
                    sq_d.state = CW_POUT;
                end
            end
            CW_POUT: begin
                if (fire_i) begin
                    if (last_word) begin
                        sq_d.state = CW_CHECK;
                    end else begin
                        sq_d.idx   = sq_q.idx + LEN_W'(1);
                        sq_d.state = CW_PREQ;
                    end
                end
            end
            CW_DONE: sq_d.state = CW_IDLE;
            default: sq_d.state = CW_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q       <= '0;
            sq_q.state <= CW_IDLE;
        end else begin
            sq_q <= sq_d;
        end
    end

    always_comb begin
        mem_req_o  = (sq_q.state == CW_HREQ) || (sq_q.state == CW_PREQ);
        mem_addr_o = '0;
        if (sq_q.state == CW_HREQ) mem_addr_o = sq_q.base;
        if (sq_q.state == CW_PREQ) mem_addr_o = {pay_addr[MEM_AW-1:2], 2'b00};
    end

    assign hdr_len_o = rd_len;
    assign busy_o    = (sq_q.state != CW_IDLE);
    assign done_o    = (sq_q.state == CW_DONE);
    assign err_o     = sq_q.err;

    // R11: a pending read keeps its address until accepted
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o));

    // R8: done lasts one cycle
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2: a clean finish only on an end-marked link
    assert_end_marker_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> sq_q.link[END_BIT]);

endmodule

// File: rtl/chain_walker.sv
module chain_walker #(
    parameter int ADDR_W     = 24,
    parameter int MEM_AW     = 21,
    parameter int DATA_W     = 32,
    parameter int LEN_W      = 8,
    parameter int COST_W     = 32,
    parameter int END_BIT    = 23,
    parameter int NODE_COST  = 10,
    parameter int PAY_COST   = 5,
    parameter int LOOP_LIMIT = 8192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    output logic              mem_req_o,
    output logic [MEM_AW-1:0] mem_addr_o,
    input  logic              mem_ack_i,
    input  logic              mem_rvalid_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              cmd_valid_o,
    output logic [DATA_W-1:0] cmd_data_o,
    input  logic              cmd_ready_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [COST_W-1:0] cost_o,
    output logic              loop_err_o
);

    logic             clear_w, hdr_take_w, load_w, limit_w, fire_w;
    logic [LEN_W-1:0] hdr_len_w;

    assign fire_w = cmd_valid_o && cmd_ready_i;

    chain_walker_seq #(
        .ADDR_W (ADDR_W), .MEM_AW(MEM_AW), .DATA_W(DATA_W),
        .LEN_W  (LEN_W),  .END_BIT(END_BIT)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .start_addr_i(start_addr_i),
        .mem_req_o   (mem_req_o),
        .mem_addr_o  (mem_addr_o),
        .mem_ack_i   (mem_ack_i),
        .mem_rvalid_i(mem_rvalid_i),
        .mem_rdata_i (mem_rdata_i),
        .limit_hit_i (limit_w),
        .fire_i      (fire_w),
        .clear_o     (clear_w),
        .hdr_take_o  (hdr_take_w),
        .hdr_len_o   (hdr_len_w),
        .load_o      (load_w),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .err_o       (loop_err_o)
    );

    chain_walker_tally #(
        .LEN_W(LEN_W), .COST_W(COST_W), .NODE_COST(NODE_COST),
        .PAY_COST(PAY_COST), .LOOP_LIMIT(LOOP_LIMIT)
    ) u_tally (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear_w),
        .add_i      (hdr_take_w),
        .len_i      (hdr_len_w),
        .cost_o     (cost_o),
        .limit_hit_o(limit_w)
    );

    chain_walker_hold #(.DATA_W(DATA_W)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_w),
        .data_i (mem_rdata_i),
        .ready_i(cmd_ready_i),
        .valid_o(cmd_valid_o),
        .data_o (cmd_data_o)
    );

    // R11: no read is issued while a payload word is waiting
    assert_single_slot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> !mem_req_o);

endmodule

// File: tb/chain_walker_bench.sv
module chain_walker_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NCASE      = 5;

    // table: start link, expected cost, words, payload sum, loop error
    localparam logic [23:0] T_START [NCASE] = '{24'h000100, 24'h800100, 24'h600402, 24'h1FFFF8, 24'h002000};
    localparam int          T_COST  [NCASE] = '{45, 0, 32, 18, 270};
    localparam int          T_CNT   [NCASE] = '{5, 0, 2, 3, 255};
    localparam int          T_SUM   [NCASE] = '{15, 0, 13, 27, 255};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [23:0] start_addr_i = '0;
    logic        mem_req_o, mem_ack_i, mem_rvalid_i;
    logic [20:0] mem_addr_o;
    logic [31:0] mem_rdata_i;
    logic        cmd_valid_o, cmd_ready_i;
    logic [31:0] cmd_data_o;
    logic        busy_o, done_o, loop_err_o;
    logic [31:0] cost_o;

    logic [31:0] mem [int];
    logic [15:0] lfsr;
    int          rx_cnt, rx_sum, reads;
    int          total, bad;

    always #(CLK_PERIOD/2) clk = ~clk;

    chain_walker u_chain_walker (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_ack_i(mem_ack_i),
        .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
        .cmd_valid_o(cmd_valid_o), .cmd_data_o(cmd_data_o), .cmd_ready_i(cmd_ready_i),
        .busy_o(busy_o), .done_o(done_o), .cost_o(cost_o), .loop_err_o(loop_err_o)
    );

    assign mem_ack_i   = mem_req_o && (lfsr[0] || lfsr[3]);
    assign cmd_ready_i = lfsr[5] || lfsr[9];

    always @(posedge clk) begin
        lfsr <= (lfsr == '0) ? 16'hACE1 : {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_rvalid_i <= 1'b0;
        if (mem_req_o && mem_ack_i) begin
            mem_rvalid_i <= 1'b1;
            mem_rdata_i  <= mem.exists(int'(mem_addr_o >> 2)) ? mem[int'(mem_addr_o >> 2)] : 32'h0;
            reads <= reads + 1;
        end
        if (cmd_valid_o && cmd_ready_i) begin
            rx_cnt <= rx_cnt + 1;
            rx_sum <= rx_sum + int'(cmd_data_o);
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic put(input int byte_a, input logic [31:0] v);
        mem[byte_a >> 2] = v;
    endtask

    task automatic pulse_start(input logic [23:0] a);
        @(negedge clk);
        start_addr_i = a;
        start_i      = 1'b1;
        @(negedge clk);
        start_i      = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int c = 0; c < 120000; c++) begin
            if (done_o) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        bit seen;
        int c0, s0, r0;
        total = 0; bad = 0; rx_cnt = 0; rx_sum = 0; reads = 0;
        lfsr = 16'hACE1; mem_rdata_i = '0; mem_rvalid_i = 1'b0;

        // R1 header layout {len[31:24], link[23:0]}
        put(32'h100, {8'd2, 24'h000200}); put(32'h104, 1); put(32'h108, 2);
        put(32'h200, {8'd0, 24'h000300});                 // R4 empty block
        put(32'h300, {8'd3, 24'h800000}); put(32'h304, 3); put(32'h308, 4); put(32'h30C, 5);
        put(32'h400, {8'd1, 24'h7FF500}); put(32'h404, 6); // R3 high bits dropped
        put(32'h1FF500, {8'd1, 24'hFFFFFF}); put(32'h1FF504, 7);
        put(32'h1FFFF8, {8'd3, 24'h800000}); put(32'h1FFFFC, 8); put(32'h0, 9); put(32'h4, 10);
        put(32'h2000, {8'd255, 24'h800000});
        for (int i = 0; i < 255; i++) put(32'h2004 + 4*i, 1);
        put(32'h5000, {8'd0, 24'h005000});                // R6 self loop

        repeat (3) @(negedge clk);
        // R10 reset state
        chk(!busy_o, "R10 busy", busy_o, 0);
        chk(!done_o, "R10 done", done_o, 0);
        chk(!cmd_valid_o, "R10 cmd_valid", cmd_valid_o, 0);
        chk(!mem_req_o && !loop_err_o, "R10 req/err", mem_req_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NCASE; k++) begin
            c0 = rx_cnt; s0 = rx_sum; r0 = reads;
            pulse_start(T_START[k]);
            chk(busy_o || done_o, "R8 busy after start", busy_o, 1);
            wait_done(seen);
            chk(seen, "R8 done pulse", seen, 1);
            chk(cost_o == 32'(T_COST[k]), "R5 cost", cost_o, T_COST[k]);
            chk(!loop_err_o, "R6 no loop error", loop_err_o, 0);
            chk(rx_cnt - c0 == T_CNT[k], "R7 word count", rx_cnt - c0, T_CNT[k]);
            chk(rx_sum - s0 == T_SUM[k], "R3 R4 payload sum", rx_sum - s0, T_SUM[k]);
            if (k == 1) chk(reads == r0, "R2 no read on ended start", reads - r0, 0);
            @(negedge clk);
            chk(!done_o, "R8 single pulse", done_o, 0);
            chk(cost_o == 32'(T_COST[k]), "R5 cost held", cost_o, T_COST[k]);
        end

        // R9 start while busy is ignored
        c0 = rx_cnt; s0 = rx_sum;
        pulse_start(24'h000100);
        @(negedge clk);
        start_addr_i = 24'h002000; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done(seen);
        chk(seen && cost_o == 32'd45, "R9 cost", cost_o, 45);
        chk(rx_cnt - c0 == 5 && rx_sum - s0 == 15, "R9 words", rx_cnt - c0, 5);
        repeat (10) @(negedge clk);
        chk(!busy_o, "R9 no second walk", busy_o, 0);

        // R6 endless list cut at 8192 blocks
        c0 = rx_cnt;
        pulse_start(24'h005000);
        wait_done(seen);
        chk(seen, "R6 loop terminates", seen, 1);
        chk(loop_err_o, "R6 loop flag", loop_err_o, 1);
        chk(cost_o == 32'd81920, "R6 R5 loop cost", cost_o, 81920);
        chk(rx_cnt == c0, "R6 no payload", rx_cnt - c0, 0);
        @(negedge clk);
        chk(loop_err_o, "R6 flag held", loop_err_o, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule